// File: doc/BRIEF.md
# Cycle-Stealing DMA Controller

This is a single-channel DMA engine. While the processor owns the bus, the engine is a slave peripheral. The processor selects it and sets up a start address, a transfer length in words and a direction. When the attached I/O device signals that it has data to give or room to take, the engine asks the processor for the bus. After the grant it moves one word per granted cycle. In each such cycle it drives the memory address and the matching memory strobe, and it pulses an acknowledge to the device.

Between words the engine looks at the device request again. If the device has nothing more, the engine hands the bus back and keeps its place. When the last word has moved, the engine drops the bus request and raises an interrupt. The interrupt stays set until the processor deals with it. There are no tristate pins. Memory strobes driven by the controller come out on their own outputs, and a drive-enable output tells the pad logic when the controller owns them.

Top module: `steal_dma`

## Requirements
- R1: After reset, `bus_req`, `dev_ack`, `mem_rd`, `mem_wr` and `irq` are low, and the address, count and control registers read back as zero.
- R2: With `cpu_sel` and `cpu_wr` high and `bus_grant` low, `cpu_reg` = 0 loads the address, 1 loads the word count, and 2 loads control. Control bit 0 is the direction: 0 reads memory and writes the device, 1 reads the device and writes memory. With `cpu_sel` and `cpu_rd` high and `bus_grant` low, `cpu_rdata` returns the selected register combinationally. The control readback carries direction in bit 0 and the interrupt flag in bit 1.
- R3: When the count is nonzero and the engine is idle on the bus, a high `dev_req` at a clock edge makes `bus_req` high from the next cycle. No word moves while `bus_grant` is low.
- R4: Each cycle with `bus_req` and `bus_grant` both high is exactly one word. In that cycle `dev_ack` is high and `mem_addr` equals the current address. `mem_rd` is high for direction 0 and `mem_wr` is high for direction 1.
- R5: `bus_oe` follows `bus_grant`. `mem_rd` and `mem_wr` stay low in every cycle that moves no word.
- R6: Each word raises the address by one (modulo the address width) and lowers the count by one.
- R7: If a word leaves the count nonzero and `dev_req` is high in that cycle, `bus_req` stays high for the next cycle.
- R8: If a word leaves the count nonzero and `dev_req` is low in that cycle, `bus_req` falls in the next cycle and address and count are kept. A later high `dev_req` raises `bus_req` again. The same holds if `dev_req` goes low while a request waits for its grant.
- R9: The word that brings the count to zero sets `irq` and clears `bus_req` from the next cycle, whatever `dev_req` does. No further word moves until the engine is armed again.
- R10: `irq` stays high until a count write, or until a control write with bit 1 set. A nonzero count write arms the engine. A zero count write leaves it idle, so `dev_req` has no effect.
- R11: Processor writes presented while `bus_grant` is high leave every register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_sel | input | 1 | Selects the controller for processor access |
| cpu_reg | input | 2 | Register choice: 0 address, 1 count, 2 control |
| cpu_rd | input | 1 | Processor read strobe (slave side) |
| cpu_wr | input | 1 | Processor write strobe (slave side) |
| cpu_wdata | input | DATA_W | Processor write data |
| cpu_rdata | output | DATA_W | Register readback, zero when not read |
| bus_req | output | 1 | Request for the system bus |
| bus_grant | input | 1 | High when the processor has released the bus |
| bus_oe | output | 1 | Drive enable for address and memory strobes |
| mem_addr | output | ADDR_W | Memory address of the current word |
| mem_rd | output | 1 | Memory read strobe driven by the controller |
| mem_wr | output | 1 | Memory write strobe driven by the controller |
| dev_req | input | 1 | Device asks for a transfer |
| dev_ack | output | 1 | One-cycle acknowledge per word |
| irq | output | 1 | Transfer-complete interrupt |

## Verification
Two things can happen in the same cycle, and each has a clear winner.

The first is a processor write strobe during a granted word cycle. Random phases and a directed case present a write to a random register while a word moves. Later readbacks must show only the effect of the word: the address and count step, and the written data is lost.

The second is the last word arriving together with a change in the device request. The device drops its request, or keeps it up, exactly on the final word. The check is that completion wins: the interrupt sets, the bus request falls, and no paused state or further acknowledge follows.

// File: rtl/steal_dma_pkg.sv
// Package: steal_dma_pkg
// Shared encodings for the cycle-stealing DMA controller: the bus-side
// sequencing states and the processor register selector codes.
package steal_dma_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,   // nothing to move
        ST_ARMED = 2'd1,   // words left, waiting for the device
        ST_OWN   = 2'd2    // bus requested or held
    } dma_state_e;

    localparam int SEL_W = 2;
    localparam logic [SEL_W-1:0] RS_ADDR  = 2'd0;
    localparam logic [SEL_W-1:0] RS_COUNT = 2'd1;
    localparam logic [SEL_W-1:0] RS_CTRL  = 2'd2;

    localparam int CTRL_DIR_BIT = 0;   // 0: memory -> device, 1: device -> memory
    localparam int CTRL_IRQ_BIT = 1;   // read: interrupt flag, write 1: clear

endpackage

// File: rtl/steal_dma_regs.sv
// Module: steal_dma_regs
// Holds the processor-visible state: the current address, the remaining
// word count, the direction and the completion flag. It applies processor
// writes and the per-word step, and muxes the readback.
// Assumes: wr_en and rd_en are already gated off while the bus is granted,
// so a write and a step never meet in one cycle.
module steal_dma_regs
    import steal_dma_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int ADDR_W  = 16,
    parameter int COUNT_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic               rd_en,
    input  logic [SEL_W-1:0]   reg_sel,
    input  logic [DATA_W-1:0]  wdata,
    output logic [DATA_W-1:0]  rdata,
    input  logic               step,
    output logic [ADDR_W-1:0]  addr_o,
    output logic [COUNT_W-1:0] count_o,
    output logic               dir_o,
    output logic               irq_o,
    output logic               cnt_wr_o,
    output logic               cnt_wr_nz_o,
    output logic               cnt_last_o
);

    localparam logic [COUNT_W-1:0] ONE_WORD = COUNT_W'(1);

    logic [ADDR_W-1:0]  addr_q;
    logic [COUNT_W-1:0] count_q;
    logic               dir_q;
    logic               irq_q;
    logic               ctrl_wr;
    logic               irq_clr;

    assign cnt_wr_o    = wr_en && (reg_sel == RS_COUNT);
    assign ctrl_wr     = wr_en && (reg_sel == RS_CTRL);
    assign irq_clr     = cnt_wr_o || (ctrl_wr && wdata[CTRL_IRQ_BIT]);
    assign cnt_wr_nz_o = (wdata[COUNT_W-1:0] != '0);
    assign cnt_last_o  = (count_q == ONE_WORD);

    // Address register: processor load, otherwise advance per word.
    always_ff @(posedge clk) begin
        if (!rst_n)
            addr_q <= '0;
        else if (wr_en && (reg_sel == RS_ADDR))
            addr_q <= wdata[ADDR_W-1:0];
        else if (step)
            addr_q <= addr_q + ADDR_W'(1);
    end

    // Word count register: processor load, otherwise count down per word.
    always_ff @(posedge clk) begin
        if (!rst_n)
            count_q <= '0;
        else if (cnt_wr_o)
            count_q <= wdata[COUNT_W-1:0];
        else if (step)
            count_q <= count_q - ONE_WORD;
    end

    // Direction bit and completion flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q <= 1'b0;
            irq_q <= 1'b0;
        end else begin
            if (ctrl_wr)
                dir_q <= wdata[CTRL_DIR_BIT];
            if (step && cnt_last_o)
                irq_q <= 1'b1;
            else if (irq_clr)
                irq_q <= 1'b0;
        end
    end

    // Readback mux, zero when the processor is not reading.
    always_comb begin
        rdata = '0;
        if (rd_en) begin
            case (reg_sel)
                RS_ADDR:  rdata = DATA_W'(addr_q);
                RS_COUNT: rdata = DATA_W'(count_q);
                RS_CTRL: begin
                    rdata[CTRL_DIR_BIT] = dir_q;
                    rdata[CTRL_IRQ_BIT] = irq_q;
                end
                default:  rdata = '0;
            endcase
        end
    end

    assign addr_o  = addr_q;
    assign count_o = count_q;
    assign dir_o   = dir_q;
    assign irq_o   = irq_q;

    // R6: a word moves the address up and the count down by one.
    assert_step_moves_R6: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> (addr_q == $past(addr_q) + ADDR_W'(1)) && (count_q == $past(count_q) - ONE_WORD));

    // R11: with no processor write (writes are gated during grant) and no step, state is held.
    assert_hold_no_access_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !step) |=> $stable(addr_q) && $stable(count_q) && $stable(dir_q));

    // R10: the flag stays set until the processor clears it.
    assert_irq_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_q && !irq_clr) |=> irq_q);

endmodule

// File: rtl/steal_dma_fsm.sv
// Module: steal_dma_fsm
// Bus-side sequencing. It tracks whether words are pending, requests the
// bus on device demand, moves one word per granted cycle, and releases the
// bus on completion or when the device stops asking.
// Assumes: cnt_wr never coincides with a granted cycle.
module steal_dma_fsm
    import steal_dma_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cnt_wr,
    input  logic cnt_wr_nz,
    input  logic cnt_last,
    input  logic dev_req,
    input  logic bus_grant,
    output logic bus_req,
    output logic step
);

    dma_state_e state_q;
    dma_state_e state_d;

    assign bus_req = (state_q == ST_OWN);
    assign step    = bus_req && bus_grant;

    // Next-state choice: processor count writes first, then bus activity.
    always_comb begin
        state_d = state_q;
        if (cnt_wr) begin
            if (!cnt_wr_nz)
                state_d = ST_IDLE;
            else if (state_q == ST_IDLE)
                state_d = ST_ARMED;
        end else begin
            case (state_q)
                ST_ARMED: if (dev_req) state_d = ST_OWN;
                ST_OWN: begin
                    if (step && cnt_last)
                        state_d = ST_IDLE;
                    else if (!dev_req)
                        state_d = ST_ARMED;
                end
                default: state_d = state_q;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // R3: an armed engine with a device request asks for the bus next cycle.
    assert_req_on_demand_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ARMED && dev_req && !cnt_wr) |=> bus_req);

    // R7: a non-final word with the request still up keeps the bus request.
    assert_keep_going_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !cnt_last && dev_req) |=> bus_req);

    // R8: a non-final word with the request gone releases the bus.
    assert_pause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !cnt_last && !dev_req) |=> (!bus_req && state_q == ST_ARMED));

endmodule

// File: rtl/steal_dma.sv
// Module: steal_dma
// Top of the single-channel cycle-stealing DMA controller. It gates the
// processor slave access with the bus grant, and drives the address, the
// memory strobes and the device acknowledge for each granted word.
// Assumes: the processor raises bus_grant only in reply to bus_req, and
// pad logic uses bus_oe to turn the shared strobes around.
module steal_dma
    import steal_dma_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int ADDR_W  = 16,
    parameter int COUNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_sel,
    input  logic [SEL_W-1:0]  cpu_reg,
    input  logic              cpu_rd,
    input  logic              cpu_wr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              bus_req,
    input  logic              bus_grant,
    output logic              bus_oe,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd,
    output logic              mem_wr,
    input  logic              dev_req,
    output logic              dev_ack,
    output logic              irq
);

    logic               wr_en;
    logic               rd_en;
    logic               step;
    logic               dir;
    logic               cnt_wr;
    logic               cnt_wr_nz;
    logic               cnt_last;
    logic [COUNT_W-1:0] count;

    // Slave access exists only while the processor owns the bus.
    assign wr_en = cpu_sel && cpu_wr && !bus_grant;
    assign rd_en = cpu_sel && cpu_rd && !bus_grant;

    steal_dma_regs #(
        .DATA_W  (DATA_W),
        .ADDR_W  (ADDR_W),
        .COUNT_W (COUNT_W)
    ) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .rd_en       (rd_en),
        .reg_sel     (cpu_reg),
        .wdata       (cpu_wdata),
        .rdata       (cpu_rdata),
        .step        (step),
        .addr_o      (mem_addr),
        .count_o     (count),
        .dir_o       (dir),
        .irq_o       (irq),
        .cnt_wr_o    (cnt_wr),
        .cnt_wr_nz_o (cnt_wr_nz),
        .cnt_last_o  (cnt_last)
    );

    steal_dma_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cnt_wr    (cnt_wr),
        .cnt_wr_nz (cnt_wr_nz),
        .cnt_last  (cnt_last),
        .dev_req   (dev_req),
        .bus_grant (bus_grant),
        .bus_req   (bus_req),
        .step      (step)
    );

    // Bus-master outputs for the word in flight.
    assign bus_oe  = bus_grant;
    assign dev_ack = step;
    assign mem_rd  = step && !dir;
    assign mem_wr  = step && dir;

    // R9: the final word sets the interrupt and drops the request.
    assert_done_irq_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_ack && count == COUNT_W'(1)) |=> (irq && !bus_req));

    // R4: exactly one memory strobe accompanies each acknowledge.
    assert_one_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
        dev_ack |-> ($countones({mem_rd, mem_wr}) == 1));

    // R5: the controller never strobes memory without the grant.
    assert_strobe_grant_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd || mem_wr) |-> (bus_grant && bus_req));

endmodule

// File: tb/sim_steal_dma.sv
// Bench for steal_dma: directed corner cases plus seeded random transfer
// phases, checked against a requirement-level model kept in the bench.
module sim_steal_dma;

    localparam int CLK_PERIOD = 10;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cpu_sel = 1'b0;
    logic [1:0]    cpu_reg = 2'd0;
    logic          cpu_rd = 1'b0;
    logic          cpu_wr = 1'b0;
    logic [DW-1:0] cpu_wdata = '0;
    logic [DW-1:0] cpu_rdata;
    logic          bus_req;
    logic          bus_grant = 1'b0;
    logic          bus_oe;
    logic [DW-1:0] mem_addr;
    logic          mem_rd;
    logic          mem_wr;
    logic          dev_req = 1'b0;
    logic          dev_ack;
    logic          irq;

    int n_checks = 0;
    int n_fail = 0;

    // Model: 0 idle, 1 armed, 2 owning the bus.
    int            m_state = 0;
    logic [DW-1:0] m_addr = '0;
    logic [DW-1:0] m_cnt = '0;
    logic          m_dir = 1'b0;
    logic          m_irq = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    steal_dma u0 (
        .clk(clk), .rst_n(rst_n), .cpu_sel(cpu_sel), .cpu_reg(cpu_reg),
        .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata),
        .cpu_rdata(cpu_rdata), .bus_req(bus_req), .bus_grant(bus_grant),
        .bus_oe(bus_oe), .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .dev_req(dev_req), .dev_ack(dev_ack), .irq(irq)
    );

    task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Model of one clock edge for the bus side (no processor write).
    task automatic model_edge(input bit dreq, input bit gnt);
        if (m_state == 2 && gnt) begin
            m_addr = m_addr + 1'b1;          // R6
            if (m_cnt == 1) begin           // R9 completion wins over dev_req
                m_state = 0;
                m_irq = 1'b1;
            end else if (!dreq) begin
                m_state = 1;                // R8 pause
            end                             // else R7 keep going
            m_cnt = m_cnt - 1'b1;
        end else if (m_state == 2 && !dreq) begin
            m_state = 1;
        end else if (m_state == 1 && dreq) begin
            m_state = 2;                    // R3
        end
    endtask

    // One bus cycle; an optional processor write is offered (only when granted).
    task automatic bus_cycle(input bit dreq, input bit gnt, input bit wr_try,
                             input logic [1:0] rs, input logic [DW-1:0] wd);
        bit ack_exp;
        @(negedge clk);
        dev_req = dreq; bus_grant = gnt;
        cpu_sel = wr_try; cpu_wr = wr_try; cpu_rd = 1'b0;
        cpu_reg = rs; cpu_wdata = wd;
        #1;
        ack_exp = (m_state == 2) && gnt;
        chk(bus_req == (m_state == 2), "R3 bus_req", DW'(bus_req), DW'(m_state == 2));
        chk(dev_ack == ack_exp, "R4 dev_ack", DW'(dev_ack), DW'(ack_exp));
        if (ack_exp) begin
            chk(mem_addr == m_addr, "R4 mem_addr", mem_addr, m_addr);
            chk(mem_rd == !m_dir && mem_wr == m_dir, "R4 strobe",
                DW'({mem_wr, mem_rd}), DW'({m_dir, !m_dir}));
        end else begin
            chk(!mem_rd && !mem_wr, "R5 idle strobe", DW'({mem_wr, mem_rd}), '0);
        end
        chk(bus_oe == gnt, "R5 bus_oe", DW'(bus_oe), DW'(gnt));
        chk(irq == m_irq, "R9 irq", DW'(irq), DW'(m_irq));
        model_edge(dreq, gnt);   // R11: a write during grant changes nothing
        @(posedge clk);
    endtask

    task automatic cpu_write(input logic [1:0] rs, input logic [DW-1:0] wd);
        @(negedge clk);
        dev_req = 1'b0; bus_grant = 1'b0;
        cpu_sel = 1'b1; cpu_wr = 1'b1; cpu_rd = 1'b0; cpu_reg = rs; cpu_wdata = wd;
        case (rs)
            2'd0: m_addr = wd;
            2'd1: begin
                m_cnt = wd; m_irq = 1'b0;
                if (wd == 0) m_state = 0;
                else if (m_state == 0) m_state = 1;
            end
            2'd2: begin
                m_dir = wd[0];
                if (wd[1]) m_irq = 1'b0;
            end
            default: ;
        endcase
        @(posedge clk);
    endtask

    task automatic cpu_read(input logic [1:0] rs, input logic [DW-1:0] exp, input string tag);
        @(negedge clk);
        dev_req = 1'b0; bus_grant = 1'b0;
        cpu_sel = 1'b1; cpu_wr = 1'b0; cpu_rd = 1'b1; cpu_reg = rs; cpu_wdata = '0;
        #1;
        chk(cpu_rdata == exp, tag, cpu_rdata, exp);
        model_edge(1'b0, 1'b0);
        @(posedge clk);
    endtask

    function automatic logic [DW-1:0] ctrl_exp();
        return DW'({m_irq, m_dir});
    endfunction

    initial begin
        #(CLK_PERIOD * 100000);
        n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [DW-1:0] a0;
        int n;
        bit d;
        void'($urandom(32'd4242));
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R1 reset state
        bus_cycle(1'b0, 1'b0, 1'b0, 2'd0, '0);
        cpu_read(2'd0, '0, "R1 addr");
        cpu_read(2'd1, '0, "R1 count");
        cpu_read(2'd2, '0, "R1 ctrl");

        // R2 programming and readback
        cpu_write(2'd0, 16'h1230);
        cpu_write(2'd2, 16'h0001);
        cpu_write(2'd1, 16'd3);
        cpu_read(2'd0, 16'h1230, "R2 addr");
        cpu_read(2'd1, 16'd3, "R2 count");
        cpu_read(2'd2, 16'h0001, "R2 ctrl");

        // R3 request without grant, then one word (R4, R6), R7 continue
        bus_cycle(1'b1, 1'b0, 1'b0, 2'd0, '0);
        bus_cycle(1'b1, 1'b0, 1'b0, 2'd0, '0);
        bus_cycle(1'b1, 1'b1, 1'b0, 2'd0, '0);
        // R8 pause: word with dev_req low
        bus_cycle(1'b0, 1'b1, 1'b0, 2'd0, '0);
        bus_cycle(1'b0, 1'b0, 1'b0, 2'd0, '0);
        cpu_read(2'd0, 16'h1232, "R8 addr kept");
        cpu_read(2'd1, 16'd1, "R8 count kept");
        // R9 last word with the request still high: completion wins
        bus_cycle(1'b1, 1'b0, 1'b0, 2'd0, '0);
        bus_cycle(1'b1, 1'b1, 1'b1, 2'd0, 16'hBEEF);   // R11 write during grant
        bus_cycle(1'b1, 1'b0, 1'b0, 2'd0, '0);
        bus_cycle(1'b1, 1'b0, 1'b0, 2'd0, '0);
        cpu_read(2'd0, 16'h1233, "R11 addr after granted write");
        cpu_read(2'd2, 16'h0003, "R9 irq in ctrl");

        // R10 clear through control bit 1, then zero count leaves engine idle
        cpu_write(2'd2, 16'h0002);
        cpu_read(2'd2, 16'h0000, "R10 irq cleared");
        cpu_write(2'd1, 16'd0);
        bus_cycle(1'b1, 1'b0, 1'b0, 2'd0, '0);
        bus_cycle(1'b1, 1'b0, 1'b0, 2'd0, '0);

        // R9 last word with dev_req dropping at the same time
        cpu_write(2'd0, 16'hFFFF);
        cpu_write(2'd1, 16'd1);
        bus_cycle(1'b1, 1'b0, 1'b0, 2'd0, '0);
        bus_cycle(1'b0, 1'b1, 1'b0, 2'd0, '0);
        bus_cycle(1'b1, 1'b0, 1'b0, 2'd0, '0);
        cpu_read(2'd0, 16'h0000, "R6 address wrap");
        // R10 count write clears irq
        cpu_write(2'd1, 16'd2);
        cpu_read(2'd2, 16'h0000, "R10 count write clears irq");
        cpu_write(2'd1, 16'd0);

        // Random phases
        for (int t = 0; t < 30; t++) begin
            a0 = DW'($urandom);
            n = 1 + int'($urandom % 8);
            d = bit'($urandom % 2);
            cpu_write(2'd0, a0);
            cpu_write(2'd2, DW'(d));
            cpu_write(2'd1, DW'(n));
            for (int c = 0; c < 300 && m_state != 0; c++) begin
                bit dr;
                bit g;
                bit w;
                dr = ($urandom % 4) != 0;
                g = (m_state == 2) && (($urandom % 3) != 0);
                w = g && (($urandom % 4) == 0);
                bus_cycle(dr, g, w, 2'($urandom % 3), DW'($urandom));
            end
            cpu_read(2'd0, a0 + DW'(n), "R6 random final addr");
            cpu_read(2'd1, '0, "R9 random final count");
            cpu_read(2'd2, ctrl_exp(), "R9 random ctrl");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule